// File: doc/BRIEF.md
# Register rename mapping tracker

This block tracks which in-flight instruction last wrote each architectural register, and manages a pool of temporary physical registers that renaming draws from. The dispatch side offers a group of destination writes and a writer tag on a valid/ready port. The block raises ready only when the pool can take that many new temporaries. When a group is accepted, the block records the tag in the table entry of every destination register. Each entry keeps only the newest writer. Every write is treated as updating the whole register, so no partial-register merging is done.

Dependency tracking reads the table through a request/response port. Retirement returns a writer's temporaries through a release port. The release also clears every table entry that still names the retiring tag. A separate query port answers the availability question for any count without allocating anything. Three statistics outputs give the current pool occupancy, the peak occupancy and the number of temporaries allocated since reset. A pool limit of zero means renaming is unlimited.

Back-pressure: an allocation takes effect only in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` depends on `alloc_cnt`, so the count must be steady while valid is held. The release and read ports are always accepted. A read response appears exactly one cycle after its request.

Top module: `rename_tracker`

## Requirements
- R1: After reset, every table entry is empty (reads return hit 0), and `in_use`, `peak_use` and `total_alloc` are all 0.
- R2: With a nonzero pool limit L, `alloc_ready` is 1 exactly when `in_use + alloc_cnt <= L`, and `query_ok` is 1 exactly when `in_use + query_cnt <= L`.
- R3: With a pool limit of 0, `alloc_ready` and `query_ok` are always 1, whatever the count.
- R4: An accepted allocation writes `alloc_tag` into the entries of destination slots 0 to `alloc_cnt-1`. Slot i sits at bits [i*AREG_W +: AREG_W] of `alloc_regs`. Slots at index `alloc_cnt` or above leave their registers untouched.
- R5: `rd_req` gives a response one cycle later: `rd_resp_valid` is 1, and `rd_resp_hit`/`rd_resp_tag` show the entry of `rd_reg` as it stood before that clock edge. Hit is 0 when no in-flight writer exists.
- R6: A release clears only the entries whose tag equals `rel_tag`. Entries holding any other tag keep it.
- R7: When an accepted allocation and a release both touch the same register in one cycle, the entry takes the new allocation's tag.
- R8: `in_use` rises by the accepted count and falls by `rel_cnt` on each edge. Both apply together when they fall in the same cycle. A release larger than the available total leaves `in_use` at 0.
- R9: `total_alloc` rises by the accepted count only. An allocation offered while `alloc_ready` is 0 changes no counter and no table entry.
- R10: `peak_use` holds the largest `in_use` value seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation group offered |
| alloc_ready | output | 1 | Pool can take `alloc_cnt` temporaries |
| alloc_cnt | input | REQ_W | Number of destination writes in the group |
| alloc_regs | input | MAX_WR*AREG_W | Destination register numbers, slot 0 in the low bits |
| alloc_tag | input | TAG_W | Writer tag of the group |
| rel_valid | input | 1 | Release of a retired writer |
| rel_tag | input | TAG_W | Tag of the retired writer |
| rel_cnt | input | REQ_W | Temporaries returned by the retired writer |
| rd_req | input | 1 | Read request |
| rd_reg | input | AREG_W | Register to look up |
| rd_resp_valid | output | 1 | Read response present |
| rd_resp_hit | output | 1 | An in-flight writer exists |
| rd_resp_tag | output | TAG_W | Tag of that writer |
| query_cnt | input | REQ_W | Count for the side availability query |
| query_ok | output | 1 | `query_cnt` temporaries would fit |
| in_use | output | CNT_W | Temporaries currently held |
| peak_use | output | CNT_W | Largest `in_use` since reset |
| total_alloc | output | CNT_W | Temporaries allocated since reset |

## Verification
An allocation and a release can land in the same cycle. They meet twice: in the occupancy counter, which must net both amounts, and in a table entry, where the retiring tag and the new tag compete. The bench provokes this by releasing a tag in the same cycle that a new group renames that tag's register. It then judges the result in two ways: through a later read response, which must carry the new tag, and through `in_use`, which must move by the net amount. A second instance with the limit at zero receives the same stimulus, and its ready and query outputs must stay high throughout.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Pool admission rule shared by the allocation and query ports.
  // A limit of zero stands for an unbounded pool.
  function automatic bit fits_pool(input int unsigned used,
                                   input int unsigned req,
                                   input int unsigned limit);
    if (limit == 0) return 1'b1;
    return (used + req) <= limit;
  endfunction

endpackage

// File: rtl/rename_table.sv
module rename_table #(
  parameter int NUM_AREGS = 16,
  parameter int AREG_W    = 4,
  parameter int TAG_W     = 6,
  parameter int MAX_WR    = 2,
  parameter int REQ_W     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REQ_W-1:0]          wr_cnt,
  input  logic [MAX_WR*AREG_W-1:0]  wr_regs,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic                      clr_en,
  input  logic [TAG_W-1:0]          clr_tag,
  input  logic                      rd_req,
  input  logic [AREG_W-1:0]         rd_reg,
  output logic                      rd_resp_valid,
  output logic                      rd_resp_hit,
  output logic [TAG_W-1:0]          rd_resp_tag
);

  logic [NUM_AREGS-1:0] ent_vld;
  logic [TAG_W-1:0]     ent_tag [NUM_AREGS];

  for (genvar r = 0; r < NUM_AREGS; r++) begin : g_ent
    logic write_here;
    logic clear_here;

    always_comb begin
      write_here = 1'b0;
      for (int i = 0; i < MAX_WR; i++) begin
        if (wr_en && (32'(i) < 32'(wr_cnt)) &&
            (32'(wr_regs[i*AREG_W +: AREG_W]) == r))
          write_here = 1'b1;
      end
    end

    assign clear_here = clr_en && ent_vld[r] && (ent_tag[r] == clr_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[r] <= 1'b0;
        ent_tag[r] <= '0;
      end else if (write_here) begin
        ent_vld[r] <= 1'b1;
        ent_tag[r] <= wr_tag;
      end else if (clear_here) begin
        ent_vld[r] <= 1'b0;
      end
    end

    // R6: a matching release with no competing write empties the entry
    a_r6_clear_match: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_here && !write_here) |=> !ent_vld[r]);

    // R7: a write in the same cycle as a release keeps the new writer
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (write_here && clr_en) |=> (ent_vld[r] && ent_tag[r] == $past(wr_tag)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_resp_hit   <= 1'b0;
      rd_resp_tag   <= '0;
    end else begin
      rd_resp_valid <= rd_req;
      if (rd_req) begin
        rd_resp_hit <= ent_vld[rd_reg];
        rd_resp_tag <= ent_tag[rd_reg];
      end
    end
  end

  // R5: one response per request, exactly one cycle later
  a_r5_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_resp_valid);

endmodule

// File: rtl/rename_pool.sv
module rename_pool #(
  parameter int POOL_LIMIT = 8,
  parameter int REQ_W      = 2,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [REQ_W-1:0] alloc_cnt,
  output logic             alloc_ready,
  output logic             alloc_fire,
  input  logic [REQ_W-1:0] query_cnt,
  output logic             query_ok,
  input  logic             rel_valid,
  input  logic [REQ_W-1:0] rel_cnt,
  output logic [CNT_W-1:0] in_use,
  output logic [CNT_W-1:0] peak_use,
  output logic [CNT_W-1:0] total_alloc
);
  import rename_pkg::*;

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] acc_n;
  logic [SUM_W-1:0] rel_n;
  logic [SUM_W-1:0] gross;
  logic [SUM_W-1:0] rel_eff;
  logic [CNT_W-1:0] use_next;

  if (POOL_LIMIT == 0) begin : g_unbounded
    assign alloc_ready = 1'b1;
    assign query_ok    = 1'b1;
  end else begin : g_bounded
    assign alloc_ready = fits_pool(32'(in_use), 32'(alloc_cnt), POOL_LIMIT);
    assign query_ok    = fits_pool(32'(in_use), 32'(query_cnt), POOL_LIMIT);
  end

  assign alloc_fire = alloc_valid && alloc_ready;
  assign acc_n      = alloc_fire ? SUM_W'(alloc_cnt) : '0;
  assign rel_n      = rel_valid  ? SUM_W'(rel_cnt)   : '0;
  assign gross      = SUM_W'(in_use) + acc_n;
  assign rel_eff    = (rel_n > gross) ? gross : rel_n;
  assign use_next   = CNT_W'(gross - rel_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_use      <= '0;
      peak_use    <= '0;
      total_alloc <= '0;
    end else begin
      in_use      <= use_next;
      total_alloc <= total_alloc + CNT_W'(acc_n);
      if (use_next > peak_use) peak_use <= use_next;
    end
  end

  if (POOL_LIMIT != 0) begin : g_chk_limit
    // R2: admission control keeps occupancy within the limit
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      32'(in_use) <= POOL_LIMIT);
  end

  // R10: the peak never trails the present occupancy
  a_r10_peak_cover: assert property (@(posedge clk) disable iff (!rst_n)
    peak_use >= in_use);

  // R9: without an accepted allocation the lifetime count holds
  a_r9_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_fire |=> $stable(total_alloc));

  // R8: with no traffic the occupancy holds
  a_r8_use_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_fire && !rel_valid) |=> $stable(in_use));

endmodule

// File: rtl/rename_tracker.sv
module rename_tracker #(
  parameter int NUM_AREGS  = 16,
  parameter int TAG_W      = 6,
  parameter int MAX_WR     = 2,
  parameter int POOL_LIMIT = 8,
  parameter int CNT_W      = 16,
  parameter int AREG_W     = $clog2(NUM_AREGS),
  parameter int REQ_W      = $clog2(MAX_WR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [REQ_W-1:0]          alloc_cnt,
  input  logic [MAX_WR*AREG_W-1:0]  alloc_regs,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic                      rel_valid,
  input  logic [TAG_W-1:0]          rel_tag,
  input  logic [REQ_W-1:0]          rel_cnt,
  input  logic                      rd_req,
  input  logic [AREG_W-1:0]         rd_reg,
  output logic                      rd_resp_valid,
  output logic                      rd_resp_hit,
  output logic [TAG_W-1:0]          rd_resp_tag,
  input  logic [REQ_W-1:0]          query_cnt,
  output logic                      query_ok,
  output logic [CNT_W-1:0]          in_use,
  output logic [CNT_W-1:0]          peak_use,
  output logic [CNT_W-1:0]          total_alloc
);

  logic alloc_fire;

  rename_pool #(
    .POOL_LIMIT (POOL_LIMIT),
    .REQ_W      (REQ_W),
    .CNT_W      (CNT_W)
  ) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_cnt   (alloc_cnt),
    .alloc_ready (alloc_ready),
    .alloc_fire  (alloc_fire),
    .query_cnt   (query_cnt),
    .query_ok    (query_ok),
    .rel_valid   (rel_valid),
    .rel_cnt     (rel_cnt),
    .in_use      (in_use),
    .peak_use    (peak_use),
    .total_alloc (total_alloc)
  );

  rename_table #(
    .NUM_AREGS (NUM_AREGS),
    .AREG_W    (AREG_W),
    .TAG_W     (TAG_W),
    .MAX_WR    (MAX_WR),
    .REQ_W     (REQ_W)
  ) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (alloc_fire),
    .wr_cnt        (alloc_cnt),
    .wr_regs       (alloc_regs),
    .wr_tag        (alloc_tag),
    .clr_en        (rel_valid),
    .clr_tag       (rel_tag),
    .rd_req        (rd_req),
    .rd_reg        (rd_reg),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_hit   (rd_resp_hit),
    .rd_resp_tag   (rd_resp_tag)
  );

  // R9: a refused offer must not move the lifetime count
  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(total_alloc));

endmodule

// File: tb/tb_rename_tracker.sv
module tb_rename_tracker;
  localparam int L     = 6;
  localparam int NREG  = 16;
  localparam int TW    = 6;
  localparam int AW    = 4;
  localparam int RW    = 2;
  localparam int CW    = 16;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic          alloc_valid = 0;
  logic [RW-1:0] alloc_cnt = 0;
  logic [2*AW-1:0] alloc_regs = 0;
  logic [TW-1:0] alloc_tag = 0;
  logic          rel_valid = 0;
  logic [TW-1:0] rel_tag = 0;
  logic [RW-1:0] rel_cnt = 0;
  logic          rd_req = 0;
  logic [AW-1:0] rd_reg = 0;
  logic [RW-1:0] query_cnt = 0;

  logic alloc_ready, rd_resp_valid, rd_resp_hit, query_ok;
  logic [TW-1:0] rd_resp_tag;
  logic [CW-1:0] in_use, peak_use, total_alloc;
  logic inf_ready, inf_rv, inf_hit, inf_qok;
  logic [TW-1:0] inf_tag;
  logic [CW-1:0] inf_use, inf_peak, inf_total;

  rename_tracker #(.NUM_AREGS(NREG), .TAG_W(TW), .MAX_WR(2), .POOL_LIMIT(L), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_cnt(alloc_cnt), .alloc_regs(alloc_regs), .alloc_tag(alloc_tag),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_cnt(rel_cnt),
    .rd_req(rd_req), .rd_reg(rd_reg), .rd_resp_valid(rd_resp_valid),
    .rd_resp_hit(rd_resp_hit), .rd_resp_tag(rd_resp_tag),
    .query_cnt(query_cnt), .query_ok(query_ok),
    .in_use(in_use), .peak_use(peak_use), .total_alloc(total_alloc));

  rename_tracker #(.NUM_AREGS(NREG), .TAG_W(TW), .MAX_WR(2), .POOL_LIMIT(0), .CNT_W(CW)) dut_inf (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(inf_ready),
    .alloc_cnt(alloc_cnt), .alloc_regs(alloc_regs), .alloc_tag(alloc_tag),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_cnt(rel_cnt),
    .rd_req(rd_req), .rd_reg(rd_reg), .rd_resp_valid(inf_rv),
    .rd_resp_hit(inf_hit), .rd_resp_tag(inf_tag),
    .query_cnt(query_cnt), .query_ok(inf_qok),
    .in_use(inf_use), .peak_use(inf_peak), .total_alloc(inf_total));

  int checks = 0;
  int errors = 0;

  // reference model
  bit          m_vld [NREG];
  bit [TW-1:0] m_tag [NREG];
  int m_use = 0, m_peak = 0, m_total = 0;

  typedef struct { bit hit; bit [TW-1:0] tag; string req; } exp_t;
  exp_t rdq[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares read responses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_resp_valid) begin
      exp_t e;
      if (rdq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual unexpected response expected none");
      end else begin
        e = rdq.pop_front();
        chk(e.req, rd_resp_hit, e.hit);
        if (e.hit) chk(e.req, rd_resp_tag, e.tag);
      end
    end
  end

  // driver: one cycle of stimulus, model update and counter checks
  task automatic step(input bit av, input int cnt, input int r0, input int r1,
                      input int tag, input bit rv, input int rtag, input int rcnt,
                      input bit rq, input int rreg, input string req);
    bit exp_ready;
    int acc, gross, reff;
    @(negedge clk);
    alloc_valid = av; alloc_cnt = RW'(cnt);
    alloc_regs = {AW'(r1), AW'(r0)}; alloc_tag = TW'(tag);
    rel_valid = rv; rel_tag = TW'(rtag); rel_cnt = RW'(rcnt);
    rd_req = rq; rd_reg = AW'(rreg);
    #1;
    exp_ready = (m_use + cnt) <= L;
    chk("R2", alloc_ready, exp_ready);
    chk("R3", inf_ready, 1);
    if (rq) begin
      exp_t e;
      e.hit = m_vld[rreg]; e.tag = m_tag[rreg]; e.req = req;
      rdq.push_back(e);
    end
    acc = (av && exp_ready) ? cnt : 0;
    // release first, then the allocation overrides (R7)
    if (rv) for (int i = 0; i < NREG; i++)
      if (m_vld[i] && m_tag[i] == TW'(rtag)) m_vld[i] = 0;
    if (acc > 0) m_vld[r0] = 1;
    if (acc > 0) m_tag[r0] = TW'(tag);
    if (acc > 1) m_vld[r1] = 1;
    if (acc > 1) m_tag[r1] = TW'(tag);
    gross = m_use + acc;
    reff = rv ? rcnt : 0;
    if (reff > gross) reff = gross;
    m_use = gross - reff;
    m_total += acc;
    if (m_use > m_peak) m_peak = m_use;
    @(posedge clk); #1;
    alloc_valid = 0; rel_valid = 0; rd_req = 0;
    chk("R8", in_use, m_use);
    chk("R9", total_alloc, m_total);
    chk("R10", peak_use, m_peak);
  endtask

  task automatic idle(); step(0,0,0,0,0, 0,0,0, 0,0, "idle"); endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk("R1", in_use, 0); chk("R1", peak_use, 0); chk("R1", total_alloc, 0);
        step(0,0,0,0,0, 0,0,0, 1,3, "R1");
        // R4: two writes, tag 5 to r3 and r7
        step(1,2,3,7,5, 0,0,0, 0,0, "R4");
        step(0,0,0,0,0, 0,0,0, 1,3, "R4");
        step(0,0,0,0,0, 0,0,0, 1,7, "R4");
        // R4: count 1, slot 1 (r4) ignored
        step(1,1,3,4,9, 0,0,0, 0,0, "R4");
        step(0,0,0,0,0, 0,0,0, 1,4, "R4");
        // R5: read in the same cycle as a write sees the old state
        step(1,2,2,8,10, 0,0,0, 1,2, "R5");
        step(0,0,0,0,0, 0,0,0, 1,2, "R5");
        // R2: query at in_use 5
        query_cnt = 2; #1; chk("R2", query_ok, 0); chk("R3", inf_qok, 1);
        query_cnt = 1; #1; chk("R2", query_ok, 1);
        // R9: refused offer changes nothing
        step(1,2,11,12,11, 0,0,0, 0,0, "R9");
        step(0,0,0,0,0, 0,0,0, 1,11, "R9");
        // R6: release tag 5: r7 cleared, r3 keeps 9
        step(0,0,0,0,0, 1,5,2, 0,0, "R6");
        step(0,0,0,0,0, 0,0,0, 1,7, "R6");
        step(0,0,0,0,0, 0,0,0, 1,3, "R6");
        // R7/R8: release tag 9 while tag 12 renames r3
        step(1,1,3,0,12, 1,9,1, 0,0, "R7");
        step(0,0,0,0,0, 0,0,0, 1,3, "R7");
        // R2/R10: fill exactly to the limit
        step(1,2,5,6,13, 0,0,0, 0,0, "R2");
        step(1,1,9,0,14, 0,0,0, 0,0, "R2");
        step(1,1,1,0,15, 0,0,0, 0,0, "R2");
        query_cnt = 1; #1; chk("R2", query_ok, 0);
        // R8: oversize release floors at zero
        step(0,0,0,0,0, 1,20,3, 0,0, "R8");
        step(0,0,0,0,0, 1,21,3, 0,0, "R8");
        step(0,0,0,0,0, 1,22,3, 0,0, "R8");
        step(0,0,0,0,0, 0,0,0, 1,5, "R6");
        idle(); idle();
        chk("R5", rdq.size(), 0);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule